// File: doc/BRIEF.md
# Controller Serial Write Port

This block is the bridge-side receiver of a three-wire serial link that a microcontroller drives to load registers and IN endpoint buffers. The controller raises a frame line, toggles a serial clock that has no relation to the bridge clock, and presents one data bit per clock. All three lines are brought into the bridge clock domain through two-flop synchronisers. Bits are assembled into bytes, least significant bit first.

Every frame starts with a one-byte header. The header either selects a register, so that each following byte becomes a one-cycle write strobe, or selects an IN endpoint buffer together with a byte count and a data toggle. An endpoint buffer keeps the most recent bytes up to its count, overwriting the oldest. When the frame line drops, the loaded endpoint is released to the USB side as ready, with its length and toggle. The USB side reads bytes by logical index and acknowledges with a pulse. A zero-count header releases an empty packet.

Top module: `ser_wr_port`

## Requirements
- R1: A rising edge on `frame_i` opens a frame. The first 8 bits received form the header: bit 7 selects a register (1) or an endpoint (0), bits 6:5 give the index, bit 4 is the data toggle and bits 3:0 are the byte count.
- R2: `sdi_i` is sampled on each rising edge of `sck_i` while the frame is open. Bytes are assembled LSB first.
- R3: For an endpoint header with count N (1 to DEPTH), the N data bytes are stored in arrival order. After the frame closes, `in_len_o` for that endpoint equals N, and byte k can be read on `usb_data_o` with `usb_idx_i`=k.
- R4: When more bytes arrive than the count, only the last N bytes are kept. The oldest are overwritten, and read order stays oldest to newest.
- R5: A header with count 0, followed by one extra SCK, releases the endpoint as ready with length 0.
- R6: When `frame_i` falls after a complete endpoint header, that endpoint's `in_ready_o` bit sets and `in_toggle_o` takes the header toggle. A new header to the same endpoint clears the bit. A `usb_ack_i` pulse for the endpoint also clears it.
- R7: For a register header, each complete data byte gives one single-cycle `reg_we_o` pulse, with `reg_addr_o` equal to header bits 6:5 and `reg_wdata_o` equal to the byte. The count and toggle bits are ignored, and no endpoint state changes.
- R8: A partial byte still pending when `frame_i` falls is discarded. A frame that ends before its header is complete changes nothing.
- R9: A header count above DEPTH (8) is treated as DEPTH.
- R10: An endpoint header whose index is not below NUM_EP (index 3) is ignored. No endpoint state changes.
- R11: After reset, every `in_ready_o` bit and `reg_we_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bridge clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| frame_i | input | 1 | Frame line from the controller, asynchronous |
| sdi_i | input | 1 | Serial data from the controller, asynchronous |
| sck_i | input | 1 | Serial clock from the controller, asynchronous |
| reg_we_o | output | 1 | Register write strobe |
| reg_addr_o | output | 2 | Register index |
| reg_wdata_o | output | 8 | Register write data |
| in_ready_o | output | NUM_EP | Endpoint loaded and released to USB side |
| in_len_o | output | NUM_EP*4 | Per-endpoint byte count, 4 bits each |
| in_toggle_o | output | NUM_EP | Per-endpoint data toggle from header |
| usb_ep_i | input | 2 | Endpoint selected for reading |
| usb_idx_i | input | 3 | Logical byte index, 0 is oldest |
| usb_data_o | output | 8 | Byte at the selected endpoint and index |
| usb_ack_i | input | NUM_EP | Per-endpoint release acknowledge pulse |

## Verification
The assertions take three things for granted about the controller. Each SCK level lasts at least two bridge clocks. SDI is steady around every rising SCK edge. At the end of a frame, SDI goes low before SIN, and SIN falls well after the last byte. The assertions also take for granted that the USB side never acknowledges an endpoint in the cycle a frame closes. The stimulus holds each SCK level for four bridge clocks and changes SDI only while SCK is low. It spaces the frame close several clocks after the last falling SCK edge, and it issues acknowledges only between frames.

// File: rtl/ser_wr_pkg.sv
package ser_wr_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned IDX_W  = 2;

  typedef struct packed {
    logic             reg_sel;
    logic [IDX_W-1:0] idx;
    logic             ti;
    logic [3:0]       cnt;
  } hdr_t;
endpackage

// File: rtl/ser_wr_sync.sv
module ser_wr_sync #(
  parameter int unsigned W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/ser_wr_deser.sv
module ser_wr_deser
  import ser_wr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sin_i,
  input  logic              sdi_i,
  input  logic              sck_i,
  output logic              frame_start_o,
  output logic              frame_end_o,
  output logic              byte_vld_o,
  output logic [BYTE_W-1:0] byte_o
);
  localparam int unsigned BC_W = $clog2(BYTE_W);

  logic              sin_q, sck_q, sck_rise;
  logic [BYTE_W-1:0] sh_q;
  logic [BC_W-1:0]   bit_cnt_q;
  logic              vld_q;
  logic [BYTE_W-1:0] byte_q;

  assign frame_start_o = sin_i & ~sin_q;
  assign frame_end_o   = ~sin_i & sin_q;
  assign sck_rise      = sck_i & ~sck_q & sin_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sin_q     <= 1'b0;
      sck_q     <= 1'b0;
      sh_q      <= '0;
      bit_cnt_q <= '0;
      vld_q     <= 1'b0;
      byte_q    <= '0;
    end else begin
      sin_q <= sin_i;
      sck_q <= sck_i;
      vld_q <= 1'b0;
      if (frame_start_o) begin
        bit_cnt_q <= '0;  // drops any partial byte
      end else if (sck_rise) begin
        sh_q      <= {sdi_i, sh_q[BYTE_W-1:1]};
        bit_cnt_q <= bit_cnt_q + 1'b1;
        if (bit_cnt_q == BC_W'(BYTE_W - 1)) begin
          vld_q  <= 1'b1;
          byte_q <= {sdi_i, sh_q[BYTE_W-1:1]};
        end
      end
    end
  end

  assign byte_vld_o = vld_q;
  assign byte_o     = byte_q;
endmodule

// File: rtl/ser_wr_fifo.sv
module ser_wr_fifo
  import ser_wr_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned LEN_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [LEN_W-1:0]  cap_i,
  input  logic              ti_i,
  input  logic              wr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              close_i,
  input  logic              ack_i,
  input  logic [PTR_W-1:0]  rd_idx_i,
  output logic [BYTE_W-1:0] rd_data_o,
  output logic              ready_o,
  output logic [LEN_W-1:0]  len_o,
  output logic              toggle_o
);
  logic [BYTE_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  wr_ptr_q;
  logic [LEN_W-1:0]  fill_q, cap_q;
  logic              ready_q, tog_q;
  logic              full;
  logic [PTR_W-1:0]  head;
  logic [LEN_W:0]    pos_sum, pos;

  assign full = (fill_q == cap_q);
  // once wrapped, the next slot to be overwritten holds the oldest byte
  assign head = full ? wr_ptr_q : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      wr_ptr_q <= '0;
      fill_q   <= '0;
      cap_q    <= '0;
      ready_q  <= 1'b0;
      tog_q    <= 1'b0;
    end else begin
      if (start_i) begin
        wr_ptr_q <= '0;
        fill_q   <= '0;
        cap_q    <= cap_i;
        tog_q    <= ti_i;
      end else if (wr_i && cap_q != '0) begin
        mem_q[wr_ptr_q] <= wdata_i;
        wr_ptr_q <= ({1'b0, wr_ptr_q} == cap_q - 1'b1) ? '0 : wr_ptr_q + 1'b1;
        if (!full) fill_q <= fill_q + 1'b1;
      end
      if (start_i)      ready_q <= 1'b0;
      else if (close_i) ready_q <= 1'b1;
      else if (ack_i)   ready_q <= 1'b0;
    end
  end

  assign pos_sum = (LEN_W + 1)'(head) + (LEN_W + 1)'(rd_idx_i);
  assign pos     = (pos_sum >= {1'b0, cap_q}) ? pos_sum - {1'b0, cap_q} : pos_sum;

  assign rd_data_o = mem_q[pos[PTR_W-1:0]];
  assign ready_o   = ready_q;
  assign len_o     = fill_q;
  assign toggle_o  = tog_q;
endmodule

// File: rtl/ser_wr_port.sv
module ser_wr_port
  import ser_wr_pkg::*;
#(
  parameter int unsigned NUM_EP = 3,
  parameter int unsigned DEPTH  = 8,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned LEN_W = $clog2(DEPTH + 1)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    frame_i,
  input  logic                    sdi_i,
  input  logic                    sck_i,
  output logic                    reg_we_o,
  output logic [IDX_W-1:0]        reg_addr_o,
  output logic [BYTE_W-1:0]       reg_wdata_o,
  output logic [NUM_EP-1:0]       in_ready_o,
  output logic [NUM_EP*LEN_W-1:0] in_len_o,
  output logic [NUM_EP-1:0]       in_toggle_o,
  input  logic [IDX_W-1:0]        usb_ep_i,
  input  logic [PTR_W-1:0]        usb_idx_i,
  output logic [BYTE_W-1:0]       usb_data_o,
  input  logic [NUM_EP-1:0]       usb_ack_i
);
  logic [2:0]        sync_q;
  logic              frame_start, frame_end, byte_vld;
  logic [BYTE_W-1:0] byte_d;
  hdr_t              hdr_q, hdr_in;
  logic              hdr_seen_q;
  logic [LEN_W-1:0]  cap_w;
  logic [BYTE_W-1:0] rd_data [NUM_EP];

  ser_wr_sync #(.W(3)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({frame_i, sdi_i, sck_i}),
    .q_o   (sync_q)
  );

  ser_wr_deser u_deser (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sin_i        (sync_q[2]),
    .sdi_i        (sync_q[1]),
    .sck_i        (sync_q[0]),
    .frame_start_o(frame_start),
    .frame_end_o  (frame_end),
    .byte_vld_o   (byte_vld),
    .byte_o       (byte_d)
  );

  assign hdr_in = hdr_t'(byte_d);
  assign cap_w  = (32'(hdr_in.cnt) > DEPTH) ? LEN_W'(DEPTH) : LEN_W'(hdr_in.cnt);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hdr_q       <= '0;
      hdr_seen_q  <= 1'b0;
      reg_we_o    <= 1'b0;
      reg_addr_o  <= '0;
      reg_wdata_o <= '0;
    end else begin
      reg_we_o <= 1'b0;
      if (frame_start) begin
        hdr_seen_q <= 1'b0;
      end else if (byte_vld && !hdr_seen_q) begin
        hdr_q      <= hdr_in;
        hdr_seen_q <= 1'b1;
      end else if (byte_vld && hdr_q.reg_sel) begin
        reg_we_o    <= 1'b1;
        reg_addr_o  <= hdr_q.idx;
        reg_wdata_o <= byte_d;
      end
    end
  end

  for (genvar e = 0; e < NUM_EP; e++) begin : g_ep
    logic hit_new, hit_cur;
    logic [LEN_W-1:0] len_e;
    assign hit_new = ~hdr_in.reg_sel & (32'(hdr_in.idx) == e);
    assign hit_cur = hdr_seen_q & ~hdr_q.reg_sel & (32'(hdr_q.idx) == e);

    ser_wr_fifo #(.DEPTH(DEPTH)) u_fifo (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .start_i  (byte_vld & ~hdr_seen_q & hit_new),
      .cap_i    (cap_w),
      .ti_i     (hdr_in.ti),
      .wr_i     (byte_vld & hit_cur),
      .wdata_i  (byte_d),
      .close_i  (frame_end & hit_cur),
      .ack_i    (usb_ack_i[e]),
      .rd_idx_i (usb_idx_i),
      .rd_data_o(rd_data[e]),
      .ready_o  (in_ready_o[e]),
      .len_o    (len_e),
      .toggle_o (in_toggle_o[e])
    );
    assign in_len_o[e*LEN_W +: LEN_W] = len_e;
  end

  always_comb begin
    usb_data_o = '0;
    for (int e = 0; e < NUM_EP; e++)
      if (32'(usb_ep_i) == e) usb_data_o = rd_data[e];
  end
endmodule

// File: rtl/ser_wr_port_chk.sv
module ser_wr_port_chk #(
  parameter int unsigned NUM_EP = 3,
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned LEN_W  = 4
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    frame_end,
  input logic                    byte_vld,
  input logic                    reg_we_o,
  input logic [NUM_EP-1:0]       in_ready_o,
  input logic [NUM_EP*LEN_W-1:0] in_len_o,
  input logic [NUM_EP-1:0]       usb_ack_i
);
  // R7
  reg_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |=> !reg_we_o);

  // R7
  reg_from_byte_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |-> $past(byte_vld));

  for (genvar e = 0; e < NUM_EP; e++) begin : g_ep
    // R6
    ready_on_close_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(in_ready_o[e]) |-> $past(frame_end));

    // R6
    ack_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (usb_ack_i[e] && !frame_end) |=> !in_ready_o[e]);

    // R9
    len_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      in_ready_o[e] |-> (32'(in_len_o[e*LEN_W +: LEN_W]) <= DEPTH));
  end
endmodule

bind ser_wr_port ser_wr_port_chk #(
  .NUM_EP(NUM_EP),
  .DEPTH (DEPTH),
  .LEN_W (LEN_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .frame_end (frame_end),
  .byte_vld  (byte_vld),
  .reg_we_o  (reg_we_o),
  .in_ready_o(in_ready_o),
  .in_len_o  (in_len_o),
  .usb_ack_i (usb_ack_i)
);

// File: tb/ser_wr_port_tb.sv
module ser_wr_port_tb;
  localparam int NEP = 3;
  localparam int DEP = 8;
  localparam int LW  = 4;

  typedef logic [7:0] bq_t[$];

  logic clk = 0, rst_n = 0;
  logic frame = 0, sdi = 0, sck = 0;
  logic reg_we;
  logic [1:0] reg_addr;
  logic [7:0] reg_wdata;
  logic [NEP-1:0] in_ready, in_toggle;
  logic [NEP*LW-1:0] in_len;
  logic [1:0] usb_ep = 0;
  logic [2:0] usb_idx = 0;
  logic [7:0] usb_data;
  logic [NEP-1:0] usb_ack = 0;

  int checks = 0, fails = 0;
  bit done = 0, cmp_en = 0;

  // reference model
  bit   m_ready[NEP];
  bit   m_tog[NEP];
  bq_t  m_q[NEP];
  logic [9:0] exp_reg[$];
  logic [9:0] got_reg[$];

  always #5 clk = ~clk;

  ser_wr_port u_dut (
    .clk_i(clk), .rst_ni(rst_n), .frame_i(frame), .sdi_i(sdi), .sck_i(sck),
    .reg_we_o(reg_we), .reg_addr_o(reg_addr), .reg_wdata_o(reg_wdata),
    .in_ready_o(in_ready), .in_len_o(in_len), .in_toggle_o(in_toggle),
    .usb_ep_i(usb_ep), .usb_idx_i(usb_idx), .usb_data_o(usb_data),
    .usb_ack_i(usb_ack)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #2;
    if (reg_we) got_reg.push_back({reg_addr, reg_wdata});
    if (cmp_en)
      for (int e = 0; e < NEP; e++) chk("R6 ready per-clock", in_ready[e], m_ready[e]);
  end

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 0; i < n; i++) begin
      sdi = b[i];
      repeat (4) @(negedge clk);
      sck = 1;
      repeat (4) @(negedge clk);
      sck = 0;
    end
  endtask

  task automatic model(input logic [7:0] h, input bq_t d);
    int e, cap;
    e = int'(h[6:5]);
    if (h[7]) begin
      foreach (d[i]) exp_reg.push_back({h[6:5], d[i]});
    end else if (e < NEP) begin
      cap = (int'(h[3:0]) > DEP) ? DEP : int'(h[3:0]);
      m_q[e] = {};
      foreach (d[i]) if (cap > 0) begin
        m_q[e].push_back(d[i]);
        if (m_q[e].size() > cap) void'(m_q[e].pop_front());
      end
      m_ready[e] = 1;
      m_tog[e]   = h[4];
    end
  endtask

  task automatic frame_tx(input logic [7:0] h, input bq_t d, input int extra, input int hbits);
    @(negedge clk);
    cmp_en = 0;
    frame = 1;
    repeat (4) @(negedge clk);
    send_bits(h, hbits);
    foreach (d[i]) send_bits(d[i], 8);
    if (extra > 0) send_bits(8'hFF, extra);
    repeat (4) @(negedge clk);
    sdi = 0;
    repeat (2) @(negedge clk);
    frame = 0;
    repeat (10) @(negedge clk);
    if (hbits == 8) model(h, d);
    cmp_en = 1;
  endtask

  task automatic check_all(input string tag);
    @(negedge clk);
    for (int e = 0; e < NEP; e++) begin
      chk({tag, " ready"}, in_ready[e], m_ready[e]);
      if (m_ready[e]) begin
        chk({tag, " len"}, int'(in_len[e*LW +: LW]), m_q[e].size());
        chk({tag, " toggle"}, in_toggle[e], m_tog[e]);
        for (int k = 0; k < m_q[e].size(); k++) begin
          usb_ep = 2'(e);
          usb_idx = 3'(k);
          #1;
          chk({tag, " data"}, usb_data, m_q[e][k]);
        end
      end
    end
    chk({tag, " R7 reg count"}, got_reg.size(), exp_reg.size());
    if (got_reg.size() == exp_reg.size())
      foreach (exp_reg[i]) chk({tag, " R7 reg write"}, got_reg[i], exp_reg[i]);
    got_reg = {};
    exp_reg = {};
  endtask

  task automatic ack(input int e);
    @(negedge clk);
    cmp_en = 0;
    usb_ack[e] = 1;
    @(negedge clk);
    usb_ack = 0;
    m_ready[e] = 0;
    repeat (2) @(negedge clk);
    cmp_en = 1;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int e = 0; e < NEP; e++) begin m_ready[e] = 0; m_tog[e] = 0; m_q[e] = {}; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11
    for (int e = 0; e < NEP; e++) chk("R11 reset ready", in_ready[e], 0);
    chk("R11 reset reg_we", reg_we, 0);
    cmp_en = 1;

    // R1 R2 R3 R6: EP0, count 3, toggle 1
    frame_tx(8'h13, '{8'hA1, 8'hB2, 8'hC3}, 0, 8);
    check_all("R3 ep0 count3");
    // R4: EP1 count 2, five bytes
    frame_tx(8'h22, '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55}, 0, 8);
    check_all("R4 ep1 overwrite");
    // R5: EP2 count 0, one extra SCK
    frame_tx(8'h50, '{}, 1, 8);
    check_all("R5 ep2 zero length");
    // R7: register target, count/TI set but ignored
    frame_tx(8'hD5, '{8'h5A, 8'hC7}, 0, 8);
    check_all("R7 register write");
    // R6: ack clears EP0
    ack(0);
    check_all("R6 ack ep0");
    // R8: partial trailing byte discarded
    frame_tx(8'h02, '{8'h6E, 8'h9D}, 3, 8);
    check_all("R8 partial byte");
    // R8: frame shorter than header changes nothing
    frame_tx(8'h21, '{}, 0, 5);
    check_all("R8 partial header");
    // R9: count 12 clamps to 8
    frame_tx(8'h3C, '{8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07, 8'h08, 8'h09, 8'h0A}, 0, 8);
    check_all("R9 count clamp");
    // R10: endpoint index 3 ignored
    frame_tx(8'h62, '{8'hEE, 8'hDD}, 0, 8);
    check_all("R10 bad endpoint");
    // R6: reload of EP2 after ack
    ack(2);
    frame_tx(8'h41, '{8'h77}, 0, 8);
    check_all("R6 reload ep2");

    done = 1;
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule